// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate Unit with Guard-Bit Accumulators

This block is the arithmetic core of a signal-processing datapath. It has two multiply-accumulate lanes that run side by side. Both lanes see the same pair of 32-bit operand words. Each lane picks the upper or lower 16-bit half of each word on its own, forms a 16x16 product in one cycle, and then adds that product to its private 40-bit accumulator, subtracts it from the accumulator, loads it into the accumulator, or leaves the accumulator as it is. The eight bits above bit 31 are guard bits, so long sums can grow past the 32-bit range before the block has to saturate.

A set of shared mode inputs governs both lanes for the current operation. These inputs choose signed or unsigned operands, fractional or integer products, saturation or wrap-around on accumulation, and the form of the write-back value: a rounded and saturated 16-bit value, or a saturated 32-bit value. Each accumulator has a sticky overflow flag that software clears explicitly. Instruction decode, the register file and pipeline interlocks live outside the block.

Top module: `dual_mac_unit`

## Requirements
- R1: Inputs presented before a rising clock edge appear on `acc_out`, `res_out` and `ovf_flag` just after that edge (one-cycle latency). Lane op code 00 (hold) leaves that lane's accumulator unchanged.
- R2: Lane i takes its multiplicand from `op_a[31:16]` when `a_hi_sel[i]`=1 and from `op_a[15:0]` when it is 0. Its multiplier comes from `op_b` in the same way, under `b_hi_sel[i]`.
- R3: With `signed_mode`=1 the 16-bit operands are two's complement. With `signed_mode`=0 they are unsigned. The product is always sign-extended to 40 bits as a two's complement value.
- R4: With `frac_mode`=1 the product is doubled. In signed mode, the single case 0x8000 times 0x8000 gives 0x7FFFFFFF instead.
- R5: Lane op codes in `lane_op[2i+1:2i]`: 01 adds the product to the accumulator, 10 subtracts it, 11 replaces the accumulator with the product, and 00 holds.
- R6: When the exact add or subtract result falls outside the signed 40-bit range, `sat_en`=1 clamps it to 0x7FFFFFFFFF or 0x8000000000. With `sat_en`=0 the result wraps modulo 2^40.
- R7: `ovf_flag[i]` sets on the edge where lane i's result goes out of the 40-bit range, whether or not `sat_en` is set. It stays set until an edge with `clr_ovf`=1. A new overflow on the same edge as a clear leaves the flag set.
- R8: With the registered `wide_en`=0, `res_out` lane i holds bits [31:16] of the accumulator, sign-extended to 32 bits. If the registered `rnd_en` was 1, 0x8000 is added to the accumulator first. If that value lies outside the signed 32-bit range, the result is 0x7FFF or 0x8000, taken by its sign.
- R9: With the registered `wide_en`=1, `res_out` lane i holds the accumulator's low 32 bits when it fits in signed 32 bits. Otherwise it holds 0x7FFFFFFF or 0x80000000, taken by its sign. No rounding is applied.
- R10: A clock edge with `rst_n`=0 clears both accumulators, both flags and the registered `wide_en`/`rnd_en`, so every output reads zero.
- R11: Both lanes update on the same edge, and each lane follows only its own op code and half selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 32 | First operand word (two halves) |
| op_b | input | 32 | Second operand word (two halves) |
| a_hi_sel | input | 2 | Per lane: 1 takes the upper half of `op_a` |
| b_hi_sel | input | 2 | Per lane: 1 takes the upper half of `op_b` |
| lane_op | input | 4 | Per lane 2-bit op code (hold/add/sub/load) |
| signed_mode | input | 1 | 1: operands are two's complement |
| frac_mode | input | 1 | 1: fractional product (doubled) |
| sat_en | input | 1 | 1: saturate accumulation at 40 bits |
| rnd_en | input | 1 | 1: round the 16-bit extraction |
| wide_en | input | 1 | 1: 32-bit extraction, 0: 16-bit |
| clr_ovf | input | 1 | Clears both sticky overflow flags |
| acc_out | output | 80 | Lane accumulators, lane 0 in bits [39:0] |
| res_out | output | 64 | Lane write-back values, lane 0 in bits [31:0] |
| ovf_flag | output | 2 | Sticky accumulator overflow flags |

## Verification
The hardest condition to reach from the ports is overflow of a 40-bit accumulator. The guard bits mean even the largest signed fractional product needs about 256 additions to leave the range. The stimulus uses unsigned fractional products of 0xFFFF by 0xFFFF, each close to 2^33, so about 64 consecutive adds drive a lane past the top of the range. It does this once with saturation and once with wrap-around, with the other lane subtracting the same product toward the negative limit. Around those runs the stimulus clears the flag on its own, and also on the same edge as a fresh overflow. It moves the accumulators into the band where 16-bit rounding reaches the saturation threshold.

// File: rtl/dmac_pkg.sv
// Package of shared types for the dual-lane multiply-accumulate unit.
// Assumes: a lane op code is two bits wide and decoded the same way in every lane.
package dmac_pkg;

    // Per-lane accumulator operation
    typedef enum logic [1:0] {
        MAC_HOLD = 2'b00,
        MAC_ADD  = 2'b01,
        MAC_SUB  = 2'b10,
        MAC_LOAD = 2'b11
    } mac_op_e;

endpackage

// File: rtl/dmac_mult.sv
// Lane multiplier: picks one half of each operand word and forms a product
// extended to the accumulator width, with the fractional doubling applied.
// Assumes: ACCW > 2*OPW + 2, so the doubled unsigned product always fits.
// The clock is used only by the guard assertion.
module dmac_mult #(
    parameter int OPW  = 16,
    parameter int ACCW = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*OPW-1:0]    a_word,
    input  logic [2*OPW-1:0]    b_word,
    input  logic                a_hi,
    input  logic                b_hi,
    input  logic                is_signed,
    input  logic                frac,
    output logic [ACCW-1:0]     prod
);
    localparam int PW   = 2 * OPW;
    localparam int XW   = 2 * (OPW + 1);
    localparam int PADW = ACCW - XW;
    localparam logic [OPW-1:0]  MOST_NEG = {1'b1, {(OPW-1){1'b0}}};
    localparam logic [ACCW-1:0] FRAC_MAX = {{(ACCW-PW+1){1'b0}}, {(PW-1){1'b1}}};

    logic [OPW-1:0]         a_half;
    logic [OPW-1:0]         b_half;
    logic signed [OPW:0]    a_ext;
    logic signed [OPW:0]    b_ext;
    logic signed [XW-1:0]   raw;
    logic [ACCW-1:0]        wide;
    logic                   both_most_neg;

    // Half selection and extension to one extra bit for signed or unsigned use
    always_comb begin
        a_half = a_hi ? a_word[PW-1:OPW] : a_word[OPW-1:0];
        b_half = b_hi ? b_word[PW-1:OPW] : b_word[OPW-1:0];
        a_ext  = $signed({is_signed & a_half[OPW-1], a_half});
        b_ext  = $signed({is_signed & b_half[OPW-1], b_half});
    end

    // Signed 17x17 multiply covers both operand formats
    always_comb begin
        raw  = a_ext * b_ext;
        wide = {{PADW{raw[XW-1]}}, raw};
    end

    // Fractional doubling, with the single most-negative square clamped
    always_comb begin
        both_most_neg = is_signed && (a_half == MOST_NEG) && (b_half == MOST_NEG);
        if (!frac)
            prod = wide;
        else if (both_most_neg)
            prod = FRAC_MAX;
        else
            prod = {wide[ACCW-2:0], 1'b0};
    end

    // R4: a signed fractional product always fits the signed 32-bit range
    frac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_signed && frac) |-> (prod[ACCW-1:PW-1] == {(ACCW-PW+1){prod[ACCW-1]}}));

endmodule

// File: rtl/dmac_accum.sv
// Lane accumulator: adds, subtracts, loads or holds a product in a 40-bit
// register. It detects range overflow, optionally saturates, and keeps a
// sticky overflow flag.
// Assumes: the product is already extended to ACCW bits.
module dmac_accum
    import dmac_pkg::*;
#(
    parameter int ACCW = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  mac_op_e         op,
    input  logic [ACCW-1:0] prod,
    input  logic            sat_en,
    input  logic            clr_ovf,
    output logic [ACCW-1:0] acc_q,
    output logic            ovf_q
);
    localparam logic [ACCW-1:0] POS_LIM = {1'b0, {(ACCW-1){1'b1}}};
    localparam logic [ACCW-1:0] NEG_LIM = {1'b1, {(ACCW-1){1'b0}}};

    logic [ACCW:0]   acc_x;
    logic [ACCW:0]   prod_x;
    logic [ACCW:0]   sum;
    logic            out_of_range;
    logic [ACCW-1:0] acc_d;

    // Exact result one bit wider than the accumulator
    always_comb begin
        acc_x  = {acc_q[ACCW-1], acc_q};
        prod_x = {prod[ACCW-1], prod};
        unique case (op)
            MAC_ADD:  sum = acc_x + prod_x;
            MAC_SUB:  sum = acc_x - prod_x;
            MAC_LOAD: sum = prod_x;
            default:  sum = acc_x;
        endcase
    end

    // Range check and saturate-or-wrap choice
    always_comb begin
        out_of_range = sum[ACCW] ^ sum[ACCW-1];
        if (out_of_range && sat_en)
            acc_d = sum[ACCW] ? NEG_LIM : POS_LIM;
        else
            acc_d = sum[ACCW-1:0];
    end

    // Accumulator register
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end

    // Sticky flag: a new overflow wins over a clear on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else
            ovf_q <= out_of_range | (ovf_q & ~clr_ovf);
    end

    // R1
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MAC_HOLD) |=> $stable(acc_q));

    // R5
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MAC_LOAD) |=> (acc_q == $past(prod)));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_ovf) |=> ovf_q);

    // R6
    sat_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && op == MAC_ADD && !prod[ACCW-1]) |=>
        ($signed(acc_q) >= $signed($past(acc_q))));

endmodule

// File: rtl/dmac_extract.sv
// Write-back extraction: turns a 40-bit accumulator into either a rounded,
// saturated 16-bit value (sign-extended to 32 bits) or a saturated 32-bit value.
// Assumes: the accumulator is a two's complement value; purely combinational.
module dmac_extract #(
    parameter int OPW  = 16,
    parameter int ACCW = 40
) (
    input  logic [ACCW-1:0]  acc,
    input  logic             wide,
    input  logic             rnd,
    output logic [2*OPW-1:0] res
);
    localparam int PW  = 2 * OPW;
    localparam int TOP = ACCW - PW + 1;
    localparam logic [ACCW:0]  RND_K    = (ACCW+1)'(1) << (OPW - 1);
    localparam logic [OPW-1:0] HALF_POS = {1'b0, {(OPW-1){1'b1}}};
    localparam logic [OPW-1:0] HALF_NEG = {1'b1, {(OPW-1){1'b0}}};
    localparam logic [PW-1:0]  WORD_POS = {1'b0, {(PW-1){1'b1}}};
    localparam logic [PW-1:0]  WORD_NEG = {1'b1, {(PW-1){1'b0}}};

    logic [ACCW:0]  rounded;
    logic           narrow_fits;
    logic [OPW-1:0] narrow_val;
    logic           wide_fits;
    logic [PW-1:0]  wide_val;

    // Narrow path: optional round-to-nearest, then a range test on the top bits
    always_comb begin
        rounded     = {acc[ACCW-1], acc} + (rnd ? RND_K : '0);
        narrow_fits = (rounded[ACCW:PW-1] == {(TOP+1){rounded[ACCW]}});
        if (narrow_fits)
            narrow_val = rounded[PW-1:OPW];
        else
            narrow_val = rounded[ACCW] ? HALF_NEG : HALF_POS;
    end

    // Wide path: saturate the low word when the guard bits hold magnitude
    always_comb begin
        wide_fits = (acc[ACCW-1:PW-1] == {TOP{acc[ACCW-1]}});
        if (wide_fits)
            wide_val = acc[PW-1:0];
        else
            wide_val = acc[ACCW-1] ? WORD_NEG : WORD_POS;
    end

    // Output selection
    always_comb begin
        if (wide)
            res = wide_val;
        else
            res = {{OPW{narrow_val[OPW-1]}}, narrow_val};
    end

endmodule

// File: rtl/dual_mac_unit.sv
// Dual-lane multiply-accumulate unit. Each lane selects operand halves,
// multiplies them, updates its accumulator, and presents an extraction for
// write-back. The mode inputs are shared by the lanes. The extraction mode is
// registered with the accumulator, so every output reflects one edge.
// Assumes: the caller holds inputs steady around the rising edge.
module dual_mac_unit
    import dmac_pkg::*;
#(
    parameter int LANES = 2,
    parameter int OPW   = 16,
    parameter int ACCW  = 40
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*OPW-1:0]       op_a,
    input  logic [2*OPW-1:0]       op_b,
    input  logic [LANES-1:0]       a_hi_sel,
    input  logic [LANES-1:0]       b_hi_sel,
    input  logic [2*LANES-1:0]     lane_op,
    input  logic                   signed_mode,
    input  logic                   frac_mode,
    input  logic                   sat_en,
    input  logic                   rnd_en,
    input  logic                   wide_en,
    input  logic                   clr_ovf,
    output logic [LANES*ACCW-1:0]  acc_out,
    output logic [LANES*2*OPW-1:0] res_out,
    output logic [LANES-1:0]       ovf_flag
);
    localparam int PW = 2 * OPW;

    logic wide_q;
    logic rnd_q;

    // Extraction mode travels with the accumulator update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
            rnd_q  <= 1'b0;
        end else begin
            wide_q <= wide_en;
            rnd_q  <= rnd_en;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [ACCW-1:0] prod;
        logic [ACCW-1:0] acc;
        logic [PW-1:0]   res;
        logic            ovf;

        dmac_mult #(.OPW(OPW), .ACCW(ACCW)) u_mult (
            .clk       (clk),
            .rst_n     (rst_n),
            .a_word    (op_a),
            .b_word    (op_b),
            .a_hi      (a_hi_sel[i]),
            .b_hi      (b_hi_sel[i]),
            .is_signed (signed_mode),
            .frac      (frac_mode),
            .prod      (prod)
        );

        dmac_accum #(.ACCW(ACCW)) u_accum (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (mac_op_e'(lane_op[2*i +: 2])),
            .prod    (prod),
            .sat_en  (sat_en),
            .clr_ovf (clr_ovf),
            .acc_q   (acc),
            .ovf_q   (ovf)
        );

        dmac_extract #(.OPW(OPW), .ACCW(ACCW)) u_extract (
            .acc  (acc),
            .wide (wide_q),
            .rnd  (rnd_q),
            .res  (res)
        );

        assign acc_out[i*ACCW +: ACCW] = acc;
        assign res_out[i*PW +: PW]     = res;
        assign ovf_flag[i]             = ovf;

        // R8
        narrow_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wide_q |-> (res[PW-1:OPW] == {OPW{res[OPW-1]}}));
    end

endmodule

// File: tb/dual_mac_unit_bench.sv
// Self-checking bench with a behavioural reference model, compared every clock.
module dual_mac_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  a_hi_sel = '0;
    logic [1:0]  b_hi_sel = '0;
    logic [3:0]  lane_op = '0;
    logic        signed_mode = 1'b0;
    logic        frac_mode = 1'b0;
    logic        sat_en = 1'b0;
    logic        rnd_en = 1'b0;
    logic        wide_en = 1'b0;
    logic        clr_ovf = 1'b0;
    logic [79:0] acc_out;
    logic [63:0] res_out;
    logic [1:0]  ovf_flag;

    int checks = 0;
    int fails = 0;

    longint m_acc [2];
    bit     m_ovf [2];
    bit     m_wide;
    bit     m_rnd;

    localparam longint ACC_MAX = (64'sd1 <<< 39) - 1;
    localparam longint ACC_MIN = -(64'sd1 <<< 39);

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_mac_unit u_dual_mac_unit (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .a_hi_sel(a_hi_sel), .b_hi_sel(b_hi_sel), .lane_op(lane_op),
        .signed_mode(signed_mode), .frac_mode(frac_mode), .sat_en(sat_en),
        .rnd_en(rnd_en), .wide_en(wide_en), .clr_ovf(clr_ovf),
        .acc_out(acc_out), .res_out(res_out), .ovf_flag(ovf_flag)
    );

    function automatic longint model_prod(int lane);
        logic [15:0] a16, b16;
        longint av, bv, p;
        a16 = a_hi_sel[lane] ? op_a[31:16] : op_a[15:0];
        b16 = b_hi_sel[lane] ? op_b[31:16] : op_b[15:0];
        av = signed_mode ? longint'($signed(a16)) : longint'({48'd0, a16});
        bv = signed_mode ? longint'($signed(b16)) : longint'({48'd0, b16});
        p = av * bv;
        if (frac_mode) begin
            if (signed_mode && a16 == 16'h8000 && b16 == 16'h8000)
                p = 64'sd2147483647;
            else
                p = p * 2;
        end
        return p;
    endfunction

    function automatic longint model_res(longint acc);
        longint r, q;
        if (m_wide) begin
            if (acc > 64'sd2147483647) return 64'sd2147483647;
            if (acc < -64'sd2147483648) return -64'sd2147483648;
            return acc;
        end
        r = acc + (m_rnd ? 64'sd32768 : 64'sd0);
        q = r >>> 16;
        if (q > 64'sd32767) q = 64'sd32767;
        if (q < -64'sd32768) q = -64'sd32768;
        return q;
    endfunction

    // Reference update, applied at the rising edge
    task automatic model_edge();
        if (!rst_n) begin
            for (int l = 0; l < 2; l++) begin
                m_acc[l] = 0;
                m_ovf[l] = 1'b0;
            end
            m_wide = 1'b0;
            m_rnd = 1'b0;
            return;
        end
        for (int l = 0; l < 2; l++) begin
            longint p, s;
            bit o;
            p = model_prod(l);
            case (lane_op[2*l +: 2])
                2'b01:   s = m_acc[l] + p;
                2'b10:   s = m_acc[l] - p;
                2'b11:   s = p;
                default: s = m_acc[l];
            endcase
            o = (s > ACC_MAX) || (s < ACC_MIN);
            if (o && sat_en)
                s = (s > 0) ? ACC_MAX : ACC_MIN;
            else if (o) begin
                s = s & 64'sh00FF_FFFF_FFFF;
                if (s > ACC_MAX) s = s - (64'sd1 <<< 40);
            end
            m_acc[l] = s;
            m_ovf[l] = o || (m_ovf[l] && !clr_ovf);
        end
        m_wide = wide_en;
        m_rnd = rnd_en;
    endtask

    task automatic compare(string tag);
        for (int l = 0; l < 2; l++) begin
            logic [39:0] exp_acc;
            logic [31:0] exp_res;
            longint rv;
            exp_acc = m_acc[l][39:0];
            rv = model_res(m_acc[l]);
            exp_res = rv[31:0];
            checks++;
            if (acc_out[l*40 +: 40] !== exp_acc) begin
                fails++;
                $display("FAIL %s lane%0d acc: got %h expected %h", tag, l, acc_out[l*40 +: 40], exp_acc);
            end
            checks++;
            if (res_out[l*32 +: 32] !== exp_res) begin
                fails++;
                $display("FAIL %s lane%0d res (%s): got %h expected %h", tag, l,
                         m_wide ? "R9" : "R8", res_out[l*32 +: 32], exp_res);
            end
            checks++;
            if (ovf_flag[l] !== m_ovf[l]) begin
                fails++;
                $display("FAIL %s lane%0d ovf (R7): got %b expected %b", tag, l, ovf_flag[l], m_ovf[l]);
            end
        end
    endtask

    // One cycle: inputs already set at the falling edge, model at rising, check after
    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        #1;
        compare(tag);
        @(negedge clk);
    endtask

    task automatic setup(logic [31:0] a, logic [31:0] b, logic [1:0] ahi, logic [1:0] bhi,
                         logic [1:0] op0, logic [1:0] op1);
        op_a = a; op_b = b; a_hi_sel = ahi; b_hi_sel = bhi; lane_op = {op1, op0};
    endtask

    task automatic modes(bit sg, bit fr, bit sat, bit rnd, bit wd, bit clr);
        signed_mode = sg; frac_mode = fr; sat_en = sat; rnd_en = rnd; wide_en = wd; clr_ovf = clr;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R10: reset state with busy inputs
        setup(32'hFFFF_7FFF, 32'h8000_1234, 2'b11, 2'b01, 2'b11, 2'b01);
        modes(1, 1, 1, 1, 1, 0);
        rst_n = 1'b0;
        tick("R10");
        tick("R10");
        rst_n = 1'b1;
        modes(0, 0, 0, 0, 0, 0);
        setup(32'h0, 32'h0, 2'b00, 2'b00, 2'b00, 2'b00);
        tick("R10");

        // R2 R3 R11: loads with different halves per lane, signed and unsigned
        modes(1, 0, 0, 0, 1, 0);
        setup(32'h1234_FFFE, 32'h0003_8001, 2'b10, 2'b01, 2'b11, 2'b11);
        tick("R2");
        modes(0, 0, 0, 0, 1, 0);
        tick("R3");
        setup(32'hABCD_00FF, 32'h7FFF_0002, 2'b01, 2'b10, 2'b11, 2'b00);
        tick("R11");
        setup(32'hABCD_00FF, 32'h7FFF_0002, 2'b01, 2'b10, 2'b00, 2'b11);
        tick("R11");

        // R4: fractional mode, including the most-negative square
        modes(1, 1, 0, 0, 1, 0);
        setup(32'h8000_8000, 32'h8000_4000, 2'b00, 2'b01, 2'b11, 2'b11);
        tick("R4");
        setup(32'h8000_7FFF, 32'h8000_8000, 2'b01, 2'b00, 2'b01, 2'b10);
        tick("R4");

        // R5 and R1: add, subtract, hold
        modes(1, 0, 0, 0, 0, 0);
        setup(32'h0100_FF00, 32'h0200_0300, 2'b01, 2'b01, 2'b01, 2'b10);
        repeat (3) tick("R5");
        setup(32'h7FFF_7FFF, 32'h7FFF_7FFF, 2'b11, 2'b11, 2'b00, 2'b00);
        repeat (2) tick("R1");

        // R8: rounding boundaries in 16-bit extraction
        modes(0, 0, 0, 1, 0, 0);
        setup(32'h0000_0001, 32'h0000_8000, 2'b00, 2'b00, 2'b11, 2'b11);
        tick("R8");
        modes(0, 0, 0, 0, 0, 0);
        tick("R8");
        modes(1, 0, 0, 1, 0, 0);
        setup(32'h0000_FFFF, 32'h0000_8000, 2'b00, 2'b00, 2'b11, 2'b11);
        tick("R8");
        // near the 32-bit edge: 0x7FFF*0x7FFF doubled, then round
        modes(1, 1, 0, 1, 0, 0);
        setup(32'h7FFF_7FFF, 32'h7FFF_7FFF, 2'b00, 2'b00, 2'b11, 2'b11);
        tick("R8");
        setup(32'h0000_0001, 32'h0000_7FFF, 2'b00, 2'b00, 2'b01, 2'b00);
        repeat (2) tick("R8");

        // R6 R7 R9: overflow with saturation (lane0 up, lane1 down)
        modes(0, 1, 1, 0, 1, 0);
        setup(32'h0000_FFFF, 32'h0000_FFFF, 2'b00, 2'b00, 2'b11, 2'b11);
        tick("R6");
        lane_op = 4'b1001;
        repeat (70) tick("R6");
        // R7: clear on a saturating edge keeps the flag
        clr_ovf = 1'b1;
        tick("R7");
        // R7: clear with no overflow drops it, then stays clear
        lane_op = 4'b0000;
        tick("R7");
        clr_ovf = 1'b0;
        tick("R7");
        wide_en = 1'b0;
        rnd_en = 1'b1;
        tick("R8");

        // R6: same run with wrap-around
        modes(0, 1, 0, 0, 1, 0);
        lane_op = 4'b1111;
        tick("R6");
        lane_op = 4'b1001;
        repeat (70) tick("R6");
        lane_op = 4'b0000;
        repeat (2) tick("R7");

        // R10: reset in mid-run clears flags and accumulators
        rst_n = 1'b0;
        tick("R10");
        rst_n = 1'b1;
        tick("R10");

        // R5: mixed random traffic across every mode
        for (int n = 0; n < 3000; n++) begin
            setup($urandom, $urandom, 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));
            modes(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom % 16) == 0);
            tick("R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule